// File: doc/BRIEF.md
# Station Address PROM Access Decoder

This block sits between two host access paths and a network controller's 16-byte station address PROM plus its register window. One path is an I/O port space, the other is a memory-mapped space. Each access is 1, 2 or 4 bytes wide. The decoder looks at the offset, the size and the alignment of each access. It then does one of three things: reads or writes the PROM bytes, forwards a word or dword access to a downstream register port, or rejects the access.

Two configuration inputs steer the decoding. The first is a word/dword I/O mode bit, which decides which sizes are legal on the I/O path. The second is a PROM write-enable bit. Multi-byte PROM accesses are built little-endian from single bytes.

Each path has a valid/ready handshake, and the decoder serves one access per cycle. A read always answers on the cycle after it is accepted.

Top module: `sap_prom_front`

## Requirements
- R1: Reset behaviour. While reset is asserted and on the first cycle after it, both read-response strobes are low and the register request is low. Each reset reloads the 16 PROM bytes from the PROM_INIT parameter, with byte i taken from bits 8i+7:8i.
- R2: PROM byte indexing. The PROM byte index is the low 4 bits of the access offset. A multi-byte PROM access places the byte at the lowest index in bits 7:0 and each following byte in the next higher lane. The index wraps modulo 16, so a 4-byte access at index 14 touches bytes 14, 15, 0 and 1.
- R3: I/O address split. On the I/O path, offsets 0x00 to 0x0F address the PROM. Offsets 0x10 and above go to the register port, which receives the full 5-bit offset.
- R4: I/O path, mode bit clear. A PROM access is accepted only if it is a byte at any offset, or a word at an even offset.
- R5: I/O path, mode bit set. A PROM access is accepted only if it is a dword at an offset that is a multiple of 4.
- R6: Size codes and rejected accesses. The size code is 0 for a byte, 1 for a word, 2 for a dword, and 3 is invalid and rejected on both paths. A rejected read returns all ones across its width: 0xFF for a byte, 0xFFFF for a word, 0xFFFFFFFF for a dword or for code 3. A rejected write changes nothing and raises no register request. On the I/O path, a byte access to the register window is rejected.
- R7: Memory-mapped register window. On the memory-mapped path, address bit 4 set selects the register window. Word and dword accesses there are forwarded with register address {0, addr[3:0]}. A byte access there is rejected as in R6.
- R8: Memory-mapped PROM. On the memory-mapped path, address bit 4 clear selects the PROM. Byte, word and dword accesses are all accepted at any alignment, whatever the mode bit.
- R9: PROM write gating. A PROM byte is written only when the write-enable bit is high in the accept cycle. PROM reads are never gated.
- R10: Arbitration. io_ready is always high. mm_ready is low in any cycle where io_valid is high, so at most one access is accepted per cycle, and the I/O path wins.
- R11: Read responses. A read accepted at a clock edge raises its path's rvalid for the next cycle only. For a register hit, the data is reg_rdata sampled in the accept cycle and masked to the access width. A write produces no rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dword_mode | input | 1 | I/O dword mode (1) or word mode (0) |
| cfg_prom_wen | input | 1 | PROM write enable |
| io_valid | input | 1 | I/O access request |
| io_ready | output | 1 | I/O access accepted |
| io_write | input | 1 | I/O access is a write |
| io_addr | input | ADDR_W | I/O offset |
| io_size | input | 2 | I/O size code |
| io_wdata | input | 32 | I/O write data, lane 0 in bits 7:0 |
| io_rvalid | output | 1 | I/O read response strobe |
| io_rdata | output | 32 | I/O read response data |
| mm_valid | input | 1 | Memory-mapped access request |
| mm_ready | output | 1 | Memory-mapped access accepted |
| mm_write | input | 1 | Memory-mapped access is a write |
| mm_addr | input | ADDR_W | Memory-mapped offset |
| mm_size | input | 2 | Memory-mapped size code |
| mm_wdata | input | 32 | Memory-mapped write data |
| mm_rvalid | output | 1 | Memory-mapped read response strobe |
| mm_rdata | output | 32 | Memory-mapped read response data |
| reg_req | output | 1 | Register port access strobe |
| reg_write | output | 1 | Register port access is a write |
| reg_addr | output | ADDR_W | Register port offset |
| reg_dword | output | 1 | Register access is a dword (0 means a word) |
| reg_wdata | output | 32 | Register port write data |
| reg_rdata | input | 32 | Register port read data, valid in the reg_req cycle |

## Verification
A decode fault shows at the ports on the cycle after the access. The read returns the wrong value, meaning stray all-ones, shifted lanes or register data in place of PROM bytes, or a register request appears when none should, or fails to appear. A corrupted PROM byte, or a write that leaked past the enable, stays hidden until a later read covers that index. For this reason every write sweep ends with a full readback of all 16 bytes, and a reset in the middle of the run checks that the initial contents come back.

// File: rtl/sap_pkg.sv
package sap_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_BAD   = 2'd3
   } sap_size_e;

   typedef enum logic [1:0] {
      TGT_DROP = 2'd0,
      TGT_PROM = 2'd1,
      TGT_REG  = 2'd2
   } sap_tgt_e;

   // byte lanes touched by a given access size
   function automatic logic [3:0] size_lanes(input sap_size_e sz);
      case (sz)
         SZ_BYTE:  return 4'b0001;
         SZ_WORD:  return 4'b0011;
         SZ_DWORD: return 4'b1111;
         default:  return 4'b0000;
      endcase
   endfunction

   // expand lane enables into a bit mask
   function automatic logic [31:0] lane_mask(input logic [3:0] lanes);
      logic [31:0] m;
      for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{lanes[k]}};
      return m;
   endfunction

   // all-ones value returned by a rejected read of the given size
   function automatic logic [31:0] reject_value(input sap_size_e sz);
      return (sz == SZ_BAD) ? 32'hFFFF_FFFF : lane_mask(size_lanes(sz));
   endfunction

endpackage

// File: rtl/sap_decode.sv
module sap_decode
   import sap_pkg::*;
#(
   parameter bit MMIO_PATH = 1'b0,
   parameter int ADDR_W    = 5,
   parameter int IDX_W     = 4
) (
   input  logic              dword_mode,
   input  logic [ADDR_W-1:0] addr,
   input  sap_size_e         size,
   output sap_tgt_e          tgt,
   output logic [3:0]        lanes,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] fwd_addr
);

   localparam int HI_W = ADDR_W - IDX_W;

   logic sz_wide;

   assign lanes   = size_lanes(size);
   assign idx     = addr[IDX_W-1:0];
   assign sz_wide = (size == SZ_WORD) || (size == SZ_DWORD);

   generate
      if (MMIO_PATH) begin : g_mmio
         logic unused_bits;
         assign unused_bits = ^{dword_mode, addr};
         // window select is the bit just above the PROM index
         always_comb begin
            if (!addr[IDX_W])
               tgt = (size != SZ_BAD) ? TGT_PROM : TGT_DROP;
            else
               tgt = sz_wide ? TGT_REG : TGT_DROP;
         end
         assign fwd_addr = {{HI_W{1'b0}}, addr[IDX_W-1:0]};
      end else begin : g_io
         logic in_window;
         logic prom_ok;
         assign in_window = |addr[ADDR_W-1:IDX_W];
         always_comb begin
            if (dword_mode)
               prom_ok = (size == SZ_DWORD) && (addr[1:0] == 2'b00);
            else
               prom_ok = (size == SZ_BYTE) || ((size == SZ_WORD) && !addr[0]);
            if (!in_window)
               tgt = prom_ok ? TGT_PROM : TGT_DROP;
            else
               tgt = sz_wide ? TGT_REG : TGT_DROP;
         end
         assign fwd_addr = addr;
      end
   endgenerate

endmodule

// File: rtl/sap_prom_store.sv
module sap_prom_store #(
   parameter int                    NBYTES = 16,
   parameter int                    LANES  = 4,
   parameter int                    IDX_W  = 4,
   parameter logic [NBYTES*8-1:0]   INIT   = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [LANES-1:0]   wr_lanes,
   input  logic [LANES*8-1:0] wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [LANES*8-1:0] rd_data
);

   logic [NBYTES*8-1:0] flat;

   generate
      for (genvar j = 0; j < NBYTES; j++) begin : g_byte
         logic [7:0] byte_q;
         logic       hit;
         logic [7:0] nxt;

         always_comb begin
            hit = 1'b0;
            nxt = byte_q;
            for (int k = 0; k < LANES; k++) begin
               if (wr_lanes[k] && ((wr_idx + IDX_W'(k)) == IDX_W'(j))) begin
                  hit = 1'b1;
                  nxt = wr_data[8*k +: 8];
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n)
               byte_q <= INIT[8*j +: 8];
            else if (wr_en && hit)
               byte_q <= nxt;
         end

         assign flat[8*j +: 8] = byte_q;
      end

      for (genvar k = 0; k < LANES; k++) begin : g_rd
         logic [IDX_W-1:0] ix;
         assign ix = rd_idx + IDX_W'(k);
         assign rd_data[8*k +: 8] = flat[{ix, 3'b000} +: 8];
      end
   endgenerate

endmodule

// File: rtl/sap_prom_front.sv
module sap_prom_front
   import sap_pkg::*;
#(
   parameter int                      ADDR_W     = 5,
   parameter int                      DATA_W     = 32,
   parameter int                      PROM_BYTES = 16,
   parameter logic [PROM_BYTES*8-1:0] PROM_INIT  = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_dword_mode,
   input  logic              cfg_prom_wen,
   input  logic              io_valid,
   output logic              io_ready,
   input  logic              io_write,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [1:0]        io_size,
   input  logic [DATA_W-1:0] io_wdata,
   output logic              io_rvalid,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              mm_valid,
   output logic              mm_ready,
   input  logic              mm_write,
   input  logic [ADDR_W-1:0] mm_addr,
   input  logic [1:0]        mm_size,
   input  logic [DATA_W-1:0] mm_wdata,
   output logic              mm_rvalid,
   output logic [DATA_W-1:0] mm_rdata,
   output logic              reg_req,
   output logic              reg_write,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_dword,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata
);

   localparam int LANES = DATA_W / 8;
   localparam int IDX_W = $clog2(PROM_BYTES);

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("sap_prom_front: DATA_W must be 32");
      end
      if (PROM_BYTES != (1 << IDX_W)) begin : g_bad_prom_bytes
         $error("sap_prom_front: PROM_BYTES must be a power of two");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr_w
         $error("sap_prom_front: ADDR_W must exceed the PROM index width");
      end
   endgenerate

   // ---------------- per-path decode ----------------
   sap_tgt_e          io_tgt, mm_tgt;
   logic [3:0]        io_lanes, mm_lanes;
   logic [IDX_W-1:0]  io_idx, mm_idx;
   logic [ADDR_W-1:0] io_fwd, mm_fwd;

   sap_decode #(.MMIO_PATH(1'b0), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec_io (
      .dword_mode (cfg_dword_mode),
      .addr       (io_addr),
      .size       (sap_size_e'(io_size)),
      .tgt        (io_tgt),
      .lanes      (io_lanes),
      .idx        (io_idx),
      .fwd_addr   (io_fwd)
   );

   sap_decode #(.MMIO_PATH(1'b1), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec_mm (
      .dword_mode (cfg_dword_mode),
      .addr       (mm_addr),
      .size       (sap_size_e'(mm_size)),
      .tgt        (mm_tgt),
      .lanes      (mm_lanes),
      .idx        (mm_idx),
      .fwd_addr   (mm_fwd)
   );

   // ---------------- arbitration: I/O path has priority ----------------
   logic io_fire, mm_fire, fire;

   assign io_ready = 1'b1;
   assign mm_ready = !io_valid;
   assign io_fire  = io_valid;
   assign mm_fire  = mm_valid && !io_valid;
   assign fire     = io_fire || mm_fire;

   sap_tgt_e          a_tgt;
   sap_size_e         a_size;
   logic              a_write;
   logic [DATA_W-1:0] a_wdata;
   logic [3:0]        a_lanes;
   logic [IDX_W-1:0]  a_idx;
   logic [ADDR_W-1:0] a_fwd;

   always_comb begin
      if (io_valid) begin
         a_tgt   = io_tgt;
         a_size  = sap_size_e'(io_size);
         a_write = io_write;
         a_wdata = io_wdata;
         a_lanes = io_lanes;
         a_idx   = io_idx;
         a_fwd   = io_fwd;
      end else begin
         a_tgt   = mm_tgt;
         a_size  = sap_size_e'(mm_size);
         a_write = mm_write;
         a_wdata = mm_wdata;
         a_lanes = mm_lanes;
         a_idx   = mm_idx;
         a_fwd   = mm_fwd;
      end
   end

   // ---------------- register port ----------------
   assign reg_req   = fire && (a_tgt == TGT_REG);
   assign reg_write = a_write;
   assign reg_addr  = a_fwd;
   assign reg_dword = (a_size == SZ_DWORD);
   assign reg_wdata = a_wdata;

   // ---------------- PROM storage ----------------
   logic              prom_we;
   logic [DATA_W-1:0] prom_rd;

   assign prom_we = fire && a_write && (a_tgt == TGT_PROM) && cfg_prom_wen;

   sap_prom_store #(
      .NBYTES (PROM_BYTES),
      .LANES  (LANES),
      .IDX_W  (IDX_W),
      .INIT   (PROM_INIT)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (prom_we),
      .wr_idx   (a_idx),
      .wr_lanes (a_lanes),
      .wr_data  (a_wdata),
      .rd_idx   (a_idx),
      .rd_data  (prom_rd)
   );

   // ---------------- response ----------------
   logic [DATA_W-1:0] width_mask;
   logic [DATA_W-1:0] rsp_next;
   logic [DATA_W-1:0] rsp_data_q;
   logic              rsp_io_q, rsp_mm_q;

   assign width_mask = lane_mask(a_lanes);

   always_comb begin
      case (a_tgt)
         TGT_PROM: rsp_next = prom_rd & width_mask;
         TGT_REG:  rsp_next = reg_rdata & width_mask;
         default:  rsp_next = reject_value(a_size);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_io_q   <= 1'b0;
         rsp_mm_q   <= 1'b0;
         rsp_data_q <= '0;
      end else begin
         rsp_io_q <= io_fire && !io_write;
         rsp_mm_q <= mm_fire && !mm_write;
         if (fire && !a_write)
            rsp_data_q <= rsp_next;
      end
   end

   assign io_rvalid = rsp_io_q;
   assign mm_rvalid = rsp_mm_q;
   assign io_rdata  = rsp_data_q;
   assign mm_rdata  = rsp_data_q;

endmodule

// File: rtl/sap_front_chk.sv
module sap_front_chk #(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_valid,
   input logic              io_ready,
   input logic              io_write,
   input logic [ADDR_W-1:0] io_addr,
   input logic [1:0]        io_size,
   input logic              mm_valid,
   input logic              mm_ready,
   input logic              mm_write,
   input logic [ADDR_W-1:0] mm_addr,
   input logic              io_rvalid,
   input logic              mm_rvalid,
   input logic              reg_req,
   input logic [ADDR_W-1:0] reg_addr
);

   logic io_acc, mm_acc;
   assign io_acc = io_valid && io_ready;
   assign mm_acc = mm_valid && mm_ready;

   // R10: never two accepts in one cycle
   a_r10_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_acc && mm_acc));

   // R3: an I/O register request always carries an offset of 0x10 or more
   a_r3_io_window_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (io_acc && reg_req) |-> (reg_addr[ADDR_W-1:4] != '0 && reg_addr == io_addr));

   // R7: a memory-mapped register request carries only the low four address bits
   a_r7_mm_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_acc && reg_req) |-> (mm_addr[4] && reg_addr[ADDR_W-1:4] == '0
                               && reg_addr[3:0] == mm_addr[3:0]));

   // R6: an I/O byte access never reaches the register port
   a_r6_io_byte_no_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (io_acc && io_size == 2'd0) |-> !reg_req);

   // R11: an accepted read answers on the next cycle
   a_r11_io_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
      (io_acc && !io_write) |=> io_rvalid);

   a_r11_mm_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_acc && !mm_write) |=> mm_rvalid);

   // R11: no response without an accepted read one cycle earlier
   a_r11_no_stray_io: assert property (@(posedge clk) disable iff (!rst_n)
      io_rvalid |-> $past(io_acc && !io_write));

   a_r11_no_stray_mm: assert property (@(posedge clk) disable iff (!rst_n)
      mm_rvalid |-> $past(mm_acc && !mm_write));

   // R10: one response at a time
   a_r10_one_response: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({io_rvalid, mm_rvalid}));

endmodule

bind sap_prom_front sap_front_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_valid  (io_valid),
   .io_ready  (io_ready),
   .io_write  (io_write),
   .io_addr   (io_addr),
   .io_size   (io_size),
   .mm_valid  (mm_valid),
   .mm_ready  (mm_ready),
   .mm_write  (mm_write),
   .mm_addr   (mm_addr),
   .io_rvalid (io_rvalid),
   .mm_rvalid (mm_rvalid),
   .reg_req   (reg_req),
   .reg_addr  (reg_addr)
);

// File: tb/sap_prom_front_tb.sv
module sap_prom_front_tb;

   localparam logic [127:0] BENCH_INIT = 128'h8F7E6D5C_4B3A2918_07F6E5D4_C3B2A190;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_dword_mode, cfg_prom_wen;
   logic        io_valid, io_write, mm_valid, mm_write;
   logic [4:0]  io_addr, mm_addr;
   logic [1:0]  io_size, mm_size;
   logic [31:0] io_wdata, mm_wdata;
   logic        io_ready, mm_ready, io_rvalid, mm_rvalid;
   logic [31:0] io_rdata, mm_rdata;
   logic        reg_req, reg_write, reg_dword;
   logic [4:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;

   always #10 clk = ~clk;

   assign reg_rdata = {8'h9C, 3'b000, reg_addr, 8'h3B, 3'b000, reg_addr};

   sap_prom_front #(.PROM_INIT(BENCH_INIT)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_dword_mode(cfg_dword_mode), .cfg_prom_wen(cfg_prom_wen),
      .io_valid(io_valid), .io_ready(io_ready), .io_write(io_write),
      .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
      .io_rvalid(io_rvalid), .io_rdata(io_rdata),
      .mm_valid(mm_valid), .mm_ready(mm_ready), .mm_write(mm_write),
      .mm_addr(mm_addr), .mm_size(mm_size), .mm_wdata(mm_wdata),
      .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata),
      .reg_req(reg_req), .reg_write(reg_write), .reg_addr(reg_addr),
      .reg_dword(reg_dword), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [7:0] model [16];

   int          reg_hits = 0;
   logic [4:0]  last_addr;
   logic        last_write, last_dword;
   logic [31:0] last_wdata;

   always @(posedge clk) begin
      if (reg_req) begin
         reg_hits   <= reg_hits + 1;
         last_addr  <= reg_addr;
         last_write <= reg_write;
         last_dword <= reg_dword;
         last_wdata <= reg_wdata;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] wmask(input logic [1:0] sz);
      case (sz)
         2'd0:    return 32'h0000_00FF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   // 0 rejected, 1 PROM, 2 register
   function automatic int tgt_of(input bit mm, input logic [4:0] a, input logic [1:0] sz);
      if (mm) begin
         if (!a[4]) return (sz != 2'd3) ? 1 : 0;
         return (sz == 2'd1 || sz == 2'd2) ? 2 : 0;
      end
      if (a[4]) return (sz == 2'd1 || sz == 2'd2) ? 2 : 0;
      if (cfg_dword_mode) return (sz == 2'd2 && a[1:0] == 2'b00) ? 1 : 0;
      return (sz == 2'd0 || (sz == 2'd1 && !a[0])) ? 1 : 0;
   endfunction

   function automatic string tag_of(input bit mm, input logic [4:0] a, input int t);
      if (t == 0) return "R6";
      if (mm) return a[4] ? "R7" : "R8";
      if (a[4]) return "R3";
      return cfg_dword_mode ? "R5" : "R4";
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 16; i++) model[i] = BENCH_INIT[8*i +: 8];
   endtask

   task automatic access(input bit mm, input bit wr, input logic [4:0] a,
                         input logic [1:0] sz, input logic [31:0] wd);
      int          t, h0, n;
      logic [4:0]  fa;
      logic [31:0] exp, rd;
      logic        rv;
      string       tag;
      t   = tgt_of(mm, a, sz);
      tag = tag_of(mm, a, t);
      fa  = mm ? {1'b0, a[3:0]} : a;
      n   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      exp = 32'h0;
      if (t == 1) begin
         for (int k = 0; k < n; k++) exp[8*k +: 8] = model[4'(a[3:0] + 4'(k))];
      end else if (t == 2) begin
         exp = {8'h9C, 3'b000, fa, 8'h3B, 3'b000, fa} & wmask(sz);
      end else begin
         exp = wmask(sz);
      end
      h0 = reg_hits;
      @(negedge clk);
      if (mm) begin
         mm_valid = 1'b1; mm_write = wr; mm_addr = a; mm_size = sz; mm_wdata = wd;
      end else begin
         io_valid = 1'b1; io_write = wr; io_addr = a; io_size = sz; io_wdata = wd;
      end
      @(negedge clk);
      io_valid = 1'b0;
      mm_valid = 1'b0;
      rv = mm ? mm_rvalid : io_rvalid;
      rd = mm ? mm_rdata : io_rdata;
      if (!wr) begin
         chk(rv == 1'b1, "R11", {31'd0, rv}, 32'd1);
         chk(rd == exp, tag, rd, exp);
      end else begin
         chk(rv == 1'b0, "R11", {31'd0, rv}, 32'd0);
      end
      chk(reg_hits == h0 + ((t == 2) ? 1 : 0), tag, 32'(reg_hits), 32'(h0 + ((t == 2) ? 1 : 0)));
      if (t == 2) begin
         chk(last_addr == fa, tag, {27'd0, last_addr}, {27'd0, fa});
         chk(last_write == wr && last_dword == (sz == 2'd2), tag,
             {30'd0, last_write, last_dword}, {30'd0, wr, sz == 2'd2});
         if (wr) chk(last_wdata == wd, tag, last_wdata, wd);
      end
      if (wr && t == 1 && cfg_prom_wen) begin
         for (int k = 0; k < n; k++) model[4'(a[3:0] + 4'(k))] = wd[8*k +: 8];
      end
   endtask

   // full PROM readback through single-byte memory-mapped reads (R2, R9)
   task automatic readback();
      for (int i = 0; i < 16; i++) access(1'b1, 1'b0, 5'(i), 2'd0, 32'h0);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0; cfg_dword_mode = 1'b0; cfg_prom_wen = 1'b0;
      io_valid = 1'b0; io_write = 1'b0; io_addr = '0; io_size = '0; io_wdata = '0;
      mm_valid = 1'b0; mm_write = 1'b0; mm_addr = '0; mm_size = '0; mm_wdata = '0;
      model_reset();
      repeat (3) @(negedge clk);
      chk(io_rvalid == 1'b0 && mm_rvalid == 1'b0 && reg_req == 1'b0, "R1",
          {29'd0, io_rvalid, mm_rvalid, reg_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(io_rvalid == 1'b0 && mm_rvalid == 1'b0 && reg_req == 1'b0, "R1",
          {29'd0, io_rvalid, mm_rvalid, reg_req}, 32'd0);
      readback();  // R1 initial contents

      // read sweeps on both paths and both modes
      for (int m = 0; m < 2; m++) begin
         cfg_dword_mode = m[0];
         for (int a = 0; a < 32; a++)
            for (int s = 0; s < 4; s++) begin
               access(1'b0, 1'b0, 5'(a), 2'(s), 32'h0);
               access(1'b1, 1'b0, 5'(a), 2'(s), 32'h0);
            end
      end

      // R9: writes with enable low are dropped
      cfg_prom_wen = 1'b0;
      cfg_dword_mode = 1'b0;
      for (int a = 0; a < 16; a++) access(1'b0, 1'b1, 5'(a), 2'd0, 32'(8'(~a)));
      for (int a = 0; a < 16; a += 2) access(1'b1, 1'b1, 5'(a), 2'd2, 32'hDEAD_BEEF);
      readback();

      // enabled write sweeps: I/O word mode, I/O dword mode, memory-mapped
      cfg_prom_wen = 1'b1;
      for (int m = 0; m < 2; m++) begin
         cfg_dword_mode = m[0];
         for (int a = 0; a < 32; a++)
            for (int s = 0; s < 4; s++)
               access(1'b0, 1'b1, 5'(a), 2'(s), {8'(a), 8'(s), 8'(m), 8'(a * 7 + s)});
         readback();
      end
      for (int a = 0; a < 32; a++)
         for (int s = 0; s < 4; s++) begin
            access(1'b1, 1'b1, 5'(a), 2'(s), {8'(a + 3), 8'(s * 5), 8'(a ^ 8'h55), 8'(a + s)});
            readback();
         end

      // R2: wrapping dword at index 14
      access(1'b1, 1'b1, 5'd14, 2'd2, 32'h44332211);
      access(1'b1, 1'b0, 5'd14, 2'd2, 32'h0);
      access(1'b1, 1'b0, 5'd0, 2'd1, 32'h0);
      chk(model[14] == 8'h11 && model[1] == 8'h44, "R2", {model[1], model[0], model[15], model[14]}, 32'h44332211);

      // R10: contention, I/O wins then memory-mapped follows
      @(negedge clk);
      io_valid = 1'b1; io_write = 1'b0; io_addr = 5'h10; io_size = 2'd2;
      mm_valid = 1'b1; mm_write = 1'b0; mm_addr = 5'h13; mm_size = 2'd1;
      #1;
      chk(io_ready == 1'b1 && mm_ready == 1'b0, "R10", {30'd0, io_ready, mm_ready}, 32'd2);
      @(negedge clk);
      io_valid = 1'b0;
      chk(io_rvalid == 1'b1 && mm_rvalid == 1'b0, "R10", {30'd0, io_rvalid, mm_rvalid}, 32'd2);
      chk(io_rdata == 32'h9C10_3B10, "R10", io_rdata, 32'h9C10_3B10);
      #1;
      chk(mm_ready == 1'b1, "R10", {31'd0, mm_ready}, 32'd1);
      @(negedge clk);
      mm_valid = 1'b0;
      chk(mm_rvalid == 1'b1 && io_rvalid == 1'b0, "R10", {30'd0, io_rvalid, mm_rvalid}, 32'd1);
      chk(mm_rdata == 32'h0000_3B03, "R7", mm_rdata, 32'h0000_3B03);

      // R1: reset in mid-run restores the initial contents
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      readback();

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         finish_run();
      end
   end

endmodule